// File: doc/BRIEF.md
# Byte Transmit Queue with Fill-Level Interrupt

This block is a byte queue that feeds a serial transmit shifter. Software reaches it through two 16-bit registers, chosen by a one-bit select. One is a data port, where each write pushes a byte. The other is a control and status word that holds the queue enable, a software release from reset, the interrupt enable and a fill threshold. The same word reports the live byte count and a sticky interrupt flag. The shifter raises a pop request whenever it wants a byte. The block answers one cycle later: either it loads the next byte into the transmit shift register and pulses a load strobe, or it pulses an idle strobe when it has nothing to send.

When queue mode is off, the data port falls back to a single-byte holding register and the queue stays empty. The interrupt flag compares the fill count with the threshold and is cleared by writing a one. Because the count is zero right after release, the flag comes up as soon as software lets the queue run. Software is therefore expected to clear it once, just after enabling.

Top module: `txq_byte_fifo`

## Requirements
- R1: After reset, the control word and the data word both read 0x0000, and irq, shift_load and tx_idle are all 0.
- R2: In the control word (reg_sel=1), the following fields read back what was last written: bit 14 (queue mode enable), bit 13 (run, where 0 holds the queue in reset) and bit 5 (interrupt enable), together with bits 4:0 (threshold). Bit 15 and bit 6 always read 0.
- R3: The data word (reg_sel=0) returns the last byte written in bits 7:0. Bits 15:8 always read 0, and whatever is written to them is ignored.
- R4: With mode=1 and run=1, a data write pushes a byte and adds one to the count in control bits 12:8. A pop request removes the oldest byte. That byte appears on shift_byte, with shift_load high, one clock after the request.
- R5: The count field reads 5'b10000 when 16 bytes are held. A push at 16 is dropped and the count does not change. If a push and a pop arrive together at 16, only the pop takes effect.
- R6: A pop request while the queue is empty loads nothing. tx_idle is high for one clock, one clock after the request.
- R7: When the count is between 1 and 15, a push and a pop in the same cycle leave the count unchanged and keep the byte order.
- R8: While run=0, the queue empties within one clock, the count reads 0, pushes are ignored and pops give tx_idle.
- R9: The flag (control bit 7) becomes set one clock after any cycle in which mode=1, run=1 and count <= threshold. With mode=0 it never sets.
- R10: A control write with bit 6 = 1 clears the flag at that clock. The flag sets again one clock later if its condition still holds. A control write with bit 6 = 0 leaves the flag unchanged.
- R11: irq is 1 exactly when the flag and the interrupt enable are both 1.
- R12: With mode=0, a data write loads a single holding byte, and a later write overwrites it. A pop moves the held byte to shift_byte with shift_load. A second pop gives tx_idle. The count stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data word, 1 control word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| pop_req | input | 1 | Shifter request for the next byte |
| shift_byte | output | 8 | Transmit shift register contents |
| shift_load | output | 1 | Pulse: shift_byte was just loaded |
| tx_idle | output | 1 | Pulse: a pop found nothing to send |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that reg_sel is stable whenever reg_wr_en is high. They also assume that control writes and data writes are never mixed within a cycle, which holds because a single select picks the target. The bench always drives a write and its select together on a falling edge and drops the strobe on the next falling edge, so each access covers exactly one rising edge. The pop request follows the same rule. The bench only pairs a pop with a push through the data port, so the push-and-pop properties see exactly the simultaneous cases the requirements describe.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LVL_W  = 5;
    localparam int unsigned CNT_FW = 5;
    // control word bit positions
    localparam int unsigned CB_MODE   = 14;
    localparam int unsigned CB_RUN    = 13;
    localparam int unsigned CB_CNT_LO = 8;
    localparam int unsigned CB_FLAG   = 7;
    localparam int unsigned CB_CLR    = 6;
    localparam int unsigned CB_IE     = 5;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/txq_ctrl_regs.sv
module txq_ctrl_regs
    import txq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [REG_W-1:0]     wdata,
    input  logic [CNT_W-1:0]     count,
    output logic                 mode,
    output logic                 run,
    output logic                 ie,
    output logic [LVL_W-1:0]     level,
    output logic                 flag,
    output logic                 irq
);
    typedef struct packed {
        logic             mode;
        logic             run;
        logic             ie;
        logic [LVL_W-1:0] level;
        logic             flag;
    } ctrl_st_t;

    ctrl_st_t ctrl_q, ctrl_d;
    logic     clr_hit;
    logic     fill_low;

    always_comb begin
        ctrl_d   = ctrl_q;
        clr_hit  = wr_ctrl & wdata[CB_CLR];
        fill_low = ctrl_q.mode & ctrl_q.run & (32'(count) <= 32'(ctrl_q.level));
        if (wr_ctrl) begin
            ctrl_d.mode  = wdata[CB_MODE];
            ctrl_d.run   = wdata[CB_RUN];
            ctrl_d.ie    = wdata[CB_IE];
            ctrl_d.level = wdata[LVL_W-1:0];
        end
        if (clr_hit) begin
            ctrl_d.flag = 1'b0;
        end else begin
            ctrl_d.flag = ctrl_q.flag | fill_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mode  = ctrl_q.mode;
    assign run   = ctrl_q.run;
    assign ie    = ctrl_q.ie;
    assign level = ctrl_q.level;
    assign flag  = ctrl_q.flag;
    assign irq   = ctrl_q.flag & ctrl_q.ie;
endmodule

// File: rtl/txq_fifo_core.sv
module txq_fifo_core #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             push,
    input  logic [DW-1:0]    din,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic [DW-1:0]    dout,
    output logic             pop_ok
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_st_t;

    ptr_st_t         ptr_q, ptr_d;
    logic            push_ok;
    logic [DW-1:0]   slot [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d   = ptr_q;
        push_ok = run & push & (ptr_q.cnt != CNT_W'(DEPTH));
        pop_ok  = run & pop & (ptr_q.cnt != '0);
        if (!run) begin
            ptr_d = '0;
        end else begin
            if (push_ok) ptr_d.wr = step(ptr_q.wr);
            if (pop_ok)  ptr_d.rd = step(ptr_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
                2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
                default: ptr_d.cnt = ptr_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && (ptr_q.wr == PTR_W'(e))) begin
                slot[e] <= din;
            end
        end
    end

    assign dout  = slot[ptr_q.rd];
    assign count = ptr_q.cnt;
endmodule

// File: rtl/txq_shift_stage.sv
module txq_shift_stage #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          wr_data,
    input  logic [DW-1:0] wbyte,
    input  logic          pop_req,
    input  logic          fifo_ok,
    input  logic [DW-1:0] fifo_byte,
    output logic [DW-1:0] last_byte,
    output logic [DW-1:0] shift_byte,
    output logic          shift_load,
    output logic          tx_idle
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic          hold_v;
        logic [DW-1:0] last;
        logic [DW-1:0] sh;
        logic          load;
        logic          idle;
    } sh_st_t;

    sh_st_t sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        sh_d.load = 1'b0;
        sh_d.idle = 1'b0;
        if (wr_data) sh_d.last = wbyte;
        if (mode) begin
            sh_d.hold_v = 1'b0;
            if (pop_req) begin
                if (fifo_ok) begin
                    sh_d.sh   = fifo_byte;
                    sh_d.load = 1'b1;
                end else begin
                    sh_d.idle = 1'b1;
                end
            end
        end else begin
            if (pop_req) begin
                if (sh_q.hold_v) begin
                    sh_d.sh     = sh_q.hold;
                    sh_d.load   = 1'b1;
                    sh_d.hold_v = 1'b0;
                end else begin
                    sh_d.idle = 1'b1;
                end
            end
            if (wr_data) begin
                sh_d.hold   = wbyte;
                sh_d.hold_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign last_byte  = sh_q.last;
    assign shift_byte = sh_q.sh;
    assign shift_load = sh_q.load;
    assign tx_idle    = sh_q.idle;
endmodule

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] shift_byte,
    output logic              shift_load,
    output logic              tx_idle,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              wr_ctrl;
    logic              wr_data;
    logic              mode_w;
    logic              run_w;
    logic              ie_w;
    logic              flag_w;
    logic [LVL_W-1:0]  lvl_w;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [BYTE_W-1:0] fifo_byte;
    logic              fifo_pop_ok;
    logic [BYTE_W-1:0] last_w;

    assign wr_ctrl = reg_wr_en & (reg_sel == SEL_CTRL);
    assign wr_data = reg_wr_en & (reg_sel == SEL_DATA);

    txq_ctrl_regs #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (reg_wdata),
        .count   (fifo_cnt),
        .mode    (mode_w),
        .run     (run_w),
        .ie      (ie_w),
        .level   (lvl_w),
        .flag    (flag_w),
        .irq     (irq)
    );

    txq_fifo_core #(.DEPTH(DEPTH), .DW(BYTE_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (mode_w & run_w),
        .push   (wr_data & mode_w),
        .din    (reg_wdata[BYTE_W-1:0]),
        .pop    (pop_req & mode_w),
        .count  (fifo_cnt),
        .dout   (fifo_byte),
        .pop_ok (fifo_pop_ok)
    );

    txq_shift_stage #(.DW(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_w),
        .wr_data    (wr_data),
        .wbyte      (reg_wdata[BYTE_W-1:0]),
        .pop_req    (pop_req),
        .fifo_ok    (fifo_pop_ok),
        .fifo_byte  (fifo_byte),
        .last_byte  (last_w),
        .shift_byte (shift_byte),
        .shift_load (shift_load),
        .tx_idle    (tx_idle)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[CB_MODE]             = mode_w;
            reg_rdata[CB_RUN]              = run_w;
            reg_rdata[CB_CNT_LO +: CNT_FW] = CNT_FW'(fifo_cnt);
            reg_rdata[CB_FLAG]             = flag_w;
            reg_rdata[CB_IE]               = ie_w;
            reg_rdata[LVL_W-1:0]           = lvl_w;
        end else begin
            reg_rdata[BYTE_W-1:0] = last_w;
        end
    end
endmodule

// File: rtl/txq_byte_fifo_chk.sv
module txq_byte_fifo_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_sel,
    input logic [15:0]      reg_wdata,
    input logic [15:0]      reg_rdata,
    input logic             pop_req,
    input logic             shift_load,
    input logic             tx_idle,
    input logic             irq,
    input logic             mode,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [4:0]       level,
    input logic             flag
);
    logic push_try;
    logic clr_wr;
    assign push_try = reg_wr_en & ~reg_sel & mode & run;
    assign clr_wr   = reg_wr_en & reg_sel & reg_wdata[6];

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && !pop_req && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));

    // R7
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && pop_req && count != '0 && count != CNT_W'(DEPTH)) |=> $stable(count));

    // R8
    held_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode && run) |=> count == '0);

    // R6
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && mode && count == '0) |=> (tx_idle && !shift_load));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !flag);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && run && 32'(count) <= 32'(level) && !clr_wr) |=> flag);

    // R2
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[15] == 1'b0 && reg_rdata[6] == 1'b0));

    // R3
    data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> reg_rdata[15:8] == 8'h00);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind txq_byte_fifo txq_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pop_req    (pop_req),
    .shift_load (shift_load),
    .tx_idle    (tx_idle),
    .irq        (irq),
    .mode       (mode_w),
    .run        (run_w),
    .count      (fifo_cnt),
    .level      (lvl_w),
    .flag       (flag_w)
);

// File: tb/txq_byte_fifo_bench.sv
`timescale 1ns/1ps
module txq_byte_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pop_req = 1'b0;
    logic [7:0]  shift_byte;
    logic        shift_load;
    logic        tx_idle;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    txq_byte_fifo u_txq_byte_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop_req(pop_req),
        .shift_byte(shift_byte), .shift_load(shift_load), .tx_idle(tx_idle), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // op: 0 push, 1 pop, 2 push+pop; kind: 0 none, 1 load, 2 idle
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] din;
        logic [4:0] exp_cnt;
        logic [1:0] kind;
        logic [7:0] exp_byte;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{2'd0, 8'h11, 5'd1, 2'd0, 8'h00},
        '{2'd0, 8'h22, 5'd2, 2'd0, 8'h00},
        '{2'd0, 8'h33, 5'd3, 2'd0, 8'h00},
        '{2'd1, 8'h00, 5'd2, 2'd1, 8'h11},
        '{2'd2, 8'h44, 5'd2, 2'd1, 8'h22},
        '{2'd1, 8'h00, 5'd1, 2'd1, 8'h33},
        '{2'd1, 8'h00, 5'd0, 2'd1, 8'h44},
        '{2'd1, 8'h00, 5'd0, 2'd2, 8'h00},
        '{2'd2, 8'h55, 5'd1, 2'd2, 8'h00},
        '{2'd1, 8'h00, 5'd0, 2'd1, 8'h55}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    // op issue: push and/or pop across one rising edge
    task automatic op(input logic do_push, input logic do_pop, input logic [7:0] b);
        @(negedge clk);
        reg_wr_en = do_push; reg_sel = 1'b0; reg_wdata = {8'h00, b}; pop_req = do_pop;
        @(negedge clk);
        reg_wr_en = 1'b0; pop_req = 1'b0;
    endtask

    function automatic logic [4:0] cnt_of(input logic [15:0] r);
        return r[12:8];
    endfunction

    initial begin
        logic [15:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(1'b1, r); chk("R1 ctrl", r, 16'h0000);
        rd(1'b0, r); chk("R1 data", r, 16'h0000);
        chk("R1 outs", {13'd0, irq, shift_load, tx_idle}, 16'h0000);

        // R2 / R9 release: flag rises one clock later
        wr(1'b1, 16'h6000);
        rd(1'b1, r); chk("R2 readback", r, 16'h6000);
        tick(1);
        rd(1'b1, r); chk("R9 flag on release", r, 16'h6080);
        chk("R11 irq off ie=0", {15'd0, irq}, 16'h0000);
        wr(1'b1, 16'h6060);
        rd(1'b1, r); chk("R10 cleared, R2 bit6 reads 0", r, 16'h6020);
        chk("R11 irq while flag 0", {15'd0, irq}, 16'h0000);
        tick(1);
        rd(1'b1, r); chk("R10 flag sets again", r, 16'h60A0);
        chk("R11 irq flag&ie", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'hE03F);
        rd(1'b1, r); chk("R2 bit15 ignored, level 31", r, 16'h60BF);
        wr(1'b1, 16'h6040);

        // R4 R6 R7 vector table
        foreach (VEC[i]) begin
            op(VEC[i].op != 2'd1, VEC[i].op != 2'd0, VEC[i].din);
            if (VEC[i].kind == 2'd1) begin
                chk($sformatf("R4 R7 vec%0d load", i), {7'd0, shift_load, shift_byte}, {8'h01, VEC[i].exp_byte});
            end else if (VEC[i].kind == 2'd2) begin
                chk($sformatf("R6 vec%0d idle", i), {14'd0, tx_idle, shift_load}, 16'h0002);
            end
            rd(1'b1, r); chk($sformatf("R4 R7 vec%0d count", i), {11'd0, cnt_of(r)}, {11'd0, VEC[i].exp_cnt});
        end

        // R5 fill to 16
        for (int k = 0; k < 16; k++) op(1'b1, 1'b0, 8'(k * 3 + 1));
        rd(1'b1, r); chk("R5 full count", {11'd0, cnt_of(r)}, 16'h0010);
        op(1'b1, 1'b0, 8'hEE);
        rd(1'b1, r); chk("R5 push at full dropped", {11'd0, cnt_of(r)}, 16'h0010);
        op(1'b1, 1'b1, 8'hEF);
        chk("R5 pop at full", {8'd0, shift_byte}, 16'h0001);
        rd(1'b1, r); chk("R5 push+pop at full", {11'd0, cnt_of(r)}, 16'h000F);

        // R9 R10 R11 threshold at count 15
        wr(1'b1, 16'h604F);
        rd(1'b1, r); chk("R10 clear write", {15'd0, r[7]}, 16'h0000);
        tick(1);
        rd(1'b1, r); chk("R9 count==level sets", {15'd0, r[7]}, 16'h0001);
        wr(1'b1, 16'h600F);
        rd(1'b1, r); chk("R10 zero write keeps flag", {15'd0, r[7]}, 16'h0001);
        wr(1'b1, 16'h606E);
        tick(2);
        rd(1'b1, r); chk("R9 count>level stays clear", {15'd0, r[7]}, 16'h0000);
        chk("R11 irq low", {15'd0, irq}, 16'h0000);
        wr(1'b1, 16'h602F);
        tick(1);
        chk("R11 irq high", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'h6040);

        // drain: order intact, dropped bytes absent
        for (int k = 1; k < 16; k++) begin
            op(1'b0, 1'b1, 8'h00);
            chk($sformatf("R5 drain %0d", k), {7'd0, shift_load, shift_byte}, {8'h01, 8'(k * 3 + 1)});
        end
        op(1'b0, 1'b1, 8'h00);
        chk("R6 empty after drain", {15'd0, tx_idle}, 16'h0001);

        // R8 transmit reset
        op(1'b1, 1'b0, 8'h91);
        op(1'b1, 1'b0, 8'h92);
        wr(1'b1, 16'h4000);
        tick(1);
        rd(1'b1, r); chk("R8 held empty", {11'd0, cnt_of(r)}, 16'h0000);
        op(1'b1, 1'b0, 8'h77);
        rd(1'b1, r); chk("R8 push ignored", {11'd0, cnt_of(r)}, 16'h0000);
        op(1'b0, 1'b1, 8'h00);
        chk("R8 pop idles", {14'd0, tx_idle, shift_load}, 16'h0002);
        wr(1'b1, 16'h6000);
        op(1'b0, 1'b1, 8'h00);
        chk("R8 old bytes gone", {14'd0, tx_idle, shift_load}, 16'h0002);

        // R12 single-byte mode
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h1234);
        rd(1'b0, r); chk("R3 data readback", r, 16'h0034);
        wr(1'b0, 16'h0055);
        rd(1'b1, r); chk("R12 count stays 0", {11'd0, cnt_of(r)}, 16'h0000);
        op(1'b0, 1'b1, 8'h00);
        chk("R12 held byte loads", {7'd0, shift_load, shift_byte}, 16'h0155);
        op(1'b0, 1'b1, 8'h00);
        chk("R12 second pop idles", {14'd0, tx_idle, shift_load}, 16'h0002);
        wr(1'b1, 16'h0040);
        tick(2);
        rd(1'b1, r); chk("R9 no flag with mode off", {15'd0, r[7]}, 16'h0000);
        wr(1'b0, 16'hABCD);
        rd(1'b0, r); chk("R3 upper bits ignored", r, 16'h00CD);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule